// File: doc/BRIEF.md
# Banked Column-Shift Delay Buffer

This block is a streaming delay buffer laid out as a small grid of rows by columns. Each accepted input word selects the current column. That column's stored values each move one row towards row 0, and the new word enters the highest row. The block then emits the whole updated column as one wide output vector. Because a column is revisited once every `NUM_COLS` accepted words, row r of the output carries the word that entered `NUM_ROWS-1-r` visits earlier at that column. This makes the block a multi-tap delay line whose tap spacing is `NUM_COLS` words.

Storage is split into independent one-read/one-write banks, one bank per row. The bank count is rounded up to a power of two, and the unused banks are not built. A word's bank comes from the low bits of its word index, and the row occupies those bits. Each bank therefore sees exactly one read and one write per column step, and a new column is accepted on every clock with no arbitration. The read issued for the shift is the only read of each bank. The output vector is built from those same read results.

Both edges use valid/ready handshakes. The output is registered one cycle behind the accept. Back-pressure from the output stalls the input and freezes all state.

Top module: `bcsb_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Every stored entry reads as zero, so on the first visit to each column, rows 0 to `NUM_ROWS-2` of the output are zero.
- R2: For an accepted word at column c, output row r (r below the last row) equals the value row r+1 of column c held before this step.
- R3: The output's last row equals the accepted input word. Row r is carried in `out_data[r*DATA_W +: DATA_W]`.
- R4: The column index starts at 0, steps by one per accepted word, wraps from `NUM_COLS-1` to 0, and does not move on cycles without an accept.
- R5: An output appears on `out_valid` in the cycle after its input is accepted. With `in_valid` and `out_ready` both held high, one output is produced every clock with no gaps.
- R6: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` stays stable and no stored value changes.
- R7: A word presented while `in_ready` is low has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DATA_W | Word to insert into the last row |
| out_valid | output | 1 | Output column vector present |
| out_ready | input | 1 | Consumer takes the vector this cycle |
| out_data | output | NUM_ROWS*DATA_W | Updated column, row r at bits r*DATA_W upward |

## Verification
The assertions assume `NUM_COLS` is at least 2. Under that assumption the column being written back never equals the column being read in the same cycle, and the read-before-write bank check depends on it. They also assume the consumer may drop `out_ready` at any time and that `in_data` is defined whenever `in_valid` is high. The stimulus keeps within these limits. It uses six columns and holds reset for several clocks. It changes `in_valid`, `in_ready`-independent data and `out_ready` only on the falling edge, with random duty cycles, so that stalls, gaps and wrap-around all occur.

// File: rtl/bcsb_pkg.sv
package bcsb_pkg;

  // Smallest power of two at or above n.
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 32; i++) begin
      if (p < n) p = p * 2;
    end
    return p;
  endfunction

  // Linear word index of (column, row) when rows sit in the low bits.
  function automatic int unsigned word_index(input int unsigned col,
                                             input int unsigned row,
                                             input int unsigned nbanks);
    return col * nbanks + row;
  endfunction

  // Bank chosen by a word index (low bits).
  function automatic int unsigned bank_pick(input int unsigned widx,
                                            input int unsigned nbanks);
    return widx % nbanks;
  endfunction

  // Slot inside the bank (upper bits of the word index).
  function automatic int unsigned bank_slot(input int unsigned widx,
                                            input int unsigned nbanks);
    return widx / nbanks;
  endfunction

  // Column after col, wrapping at ncols.
  function automatic int unsigned col_step(input int unsigned col,
                                           input int unsigned ncols);
    return (col + 1 >= ncols) ? 0 : col + 1;
  endfunction

endpackage

// File: rtl/bcsb_bank.sv
module bcsb_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  // One read and one write per cycle, never on the same slot.
  assert_port_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (rd_addr != wr_addr));

endmodule

// File: rtl/bcsb_col_seq.sv
module bcsb_col_seq
  import bcsb_pkg::*;
#(
  parameter int NUM_COLS = 16,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             commit,
  output logic [COL_W-1:0] col_ptr,
  output logic [COL_W-1:0] issued_col,
  output logic             issued_live
);

  logic [NUM_COLS-1:0] seen;
  logic [COL_W-1:0]    col_nxt;

  always_comb col_nxt = COL_W'(col_step(32'(col_ptr), NUM_COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_ptr     <= '0;
      issued_col  <= '0;
      issued_live <= 1'b0;
      seen        <= '0;
    end else begin
      if (advance) begin
        col_ptr     <= col_nxt;
        issued_col  <= col_ptr;
        issued_live <= seen[col_ptr];
      end
      if (commit) seen[issued_col] <= 1'b1;
    end
  end

  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (col_ptr == COL_W'(col_step(32'($past(col_ptr)), NUM_COLS))));

  assert_col_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(col_ptr));

endmodule

// File: rtl/bcsb_top.sv
module bcsb_top
  import bcsb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_ROWS = 5,
  parameter int NUM_COLS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_ROWS*DATA_W-1:0] out_data
);

  localparam int NUM_BANKS = int'(pow2_ceil(NUM_ROWS));
  localparam int COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  if (NUM_COLS < 2) begin : g_bad_cols
    $error("bcsb_top needs NUM_COLS of at least 2");
  end

  // Handshake events, named for the assertions.
  logic accept;
  logic fire;
  logic s1_valid;
  logic [DATA_W-1:0] s1_word;

  logic [COL_W-1:0] col_ptr;
  logic [COL_W-1:0] issued_col;
  logic             issued_live;

  logic [DATA_W-1:0] bank_q   [NUM_ROWS];
  logic [DATA_W-1:0] row_next [NUM_ROWS];

  assign in_ready  = !s1_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign fire      = s1_valid && out_ready;
  assign out_valid = s1_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
    end else begin
      if (in_ready) s1_valid <= in_valid;
      if (accept)   s1_word  <= in_data;
    end
  end

  bcsb_col_seq #(
    .NUM_COLS (NUM_COLS),
    .COL_W    (COL_W)
  ) u_col_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (accept),
    .commit      (fire),
    .col_ptr     (col_ptr),
    .issued_col  (issued_col),
    .issued_live (issued_live)
  );

  // One bank per row; banks at or above NUM_ROWS are pruned.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (b < NUM_ROWS) begin : g_live
      logic [COL_W-1:0] rd_addr;
      logic [COL_W-1:0] wr_addr;

      always_comb begin
        rd_addr = COL_W'(bank_slot(word_index(32'(col_ptr), b, NUM_BANKS), NUM_BANKS));
        wr_addr = COL_W'(bank_slot(word_index(32'(issued_col), b, NUM_BANKS), NUM_BANKS));
      end

      bcsb_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (NUM_COLS),
        .ADDR_W (COL_W)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (accept),
        .rd_addr (rd_addr),
        .rd_q    (bank_q[b]),
        .wr_en   (fire),
        .wr_addr (wr_addr),
        .wr_data (row_next[b])
      );

      if (b == NUM_ROWS - 1) begin : g_top_row
        assign row_next[b] = s1_word;
      end else begin : g_shift_row
        assign row_next[b] = issued_live ? bank_q[b+1] : '0;
      end

      assign out_data[b*DATA_W +: DATA_W] = row_next[b];
    end else begin : g_pruned
    end
  end

  assert_accept_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_last_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_data[(NUM_ROWS-1)*DATA_W +: DATA_W] == $past(in_data)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_no_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(col_ptr));

endmodule

// File: tb/bcsb_top_tb.sv
module bcsb_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 32;
  localparam int ROWS = 5;
  localparam int COLS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [ROWS*W-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  string phase = "R1";

  bcsb_top #(.DATA_W(W), .NUM_ROWS(ROWS), .NUM_COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: a plain array of columns, updated on accept.
  logic [W-1:0] m_store [COLS][ROWS];
  logic [ROWS*W-1:0] m_vec = '0;
  int  m_col = 0;
  bit  m_ov = 1'b0;

  always @(posedge clk) begin
    bit rdy;
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++)
        for (int r = 0; r < ROWS; r++) m_store[c][r] = '0;
      m_col = 0;
      m_ov  = 1'b0;
      m_vec = '0;
    end else begin
      rdy = !m_ov || out_ready;
      if (m_ov && out_ready) m_ov = 1'b0;
      if (in_valid && rdy) begin
        for (int r = 0; r < ROWS - 1; r++) m_store[m_col][r] = m_store[m_col][r+1];
        m_store[m_col][ROWS-1] = in_data;
        for (int r = 0; r < ROWS; r++) m_vec[r*W +: W] = m_store[m_col][r];
        m_ov  = 1'b1;
        m_col = (m_col + 1) % COLS;
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [ROWS*W-1:0] act, input logic [ROWS*W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  // Compare every cycle, shortly after inputs change on the falling edge.
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      check(in_ready === (!m_ov || out_ready), "R6 in_ready",
            {{(ROWS*W-1){1'b0}}, in_ready}, {{(ROWS*W-1){1'b0}}, (!m_ov || out_ready)});
      check(out_valid === m_ov, "R5 out_valid",
            {{(ROWS*W-1){1'b0}}, out_valid}, {{(ROWS*W-1){1'b0}}, m_ov});
      if (m_ov)
        check(out_data === m_vec, "R2/R3 out_data", out_data, m_vec);
    end
  end

  task automatic drive(input int n, input int pv, input int pr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = ($urandom % 100) < pv;
      out_ready = ($urandom % 100) < pr;
      in_data   = $urandom;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, then first pass over every column sees zeros.
    @(negedge clk);
    phase = "R1";
    drive(COLS, 100, 100);
    // R2: several full passes so every row fills with shifted history.
    phase = "R2";
    drive(ROWS * COLS, 100, 100);
    // R5: gapless streaming.
    phase = "R5";
    drive(3 * COLS, 100, 100);
    // R6: random back-pressure with random input gaps.
    phase = "R6";
    drive(200, 70, 50);
    // R7: data keeps changing while the block refuses it.
    phase = "R7";
    drive(120, 100, 30);
    // R4: gaps on the input; column must only step on accepts.
    phase = "R4";
    drive(150, 55, 100);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule